// File: doc/BRIEF.md
# Lines-per-Field Serial Word Decoder

This block sits behind an analog sync separator that reports how many lines it counted in each video field as an 11-bit serial word. The word is sent most significant bit first, one bit per line. The horizontal sync strobe marks each line and the vertical sync strobe marks the start of a field. The decoder rebuilds the count. It then turns the count into a format code that downstream scaler and colour-space logic can use, plus an interlaced flag and a composite-video flag that can enable a chroma filter.

The data line may change near each horizontal sync edge. For that reason the bit is not taken on the edge itself. The block measures the line period between horizontal sync falling edges and samples the bit half a period after each edge. The format outputs do not follow every field. They change only when two completed words in a row give the same format, which keeps them steady while the source is being switched.

All inputs are assumed to be synchronous to `clk`, with both sync strobes active low. A horizontal sync edge that falls in the same clock cycle as a vertical sync edge is not counted.

Top module: `fmt_word_decoder`

## Requirements
- R1: During and right after reset, `line_count` is 0, `fmt_code` is 0 (unknown), and `interlaced`, `composite` and `word_valid` are all 0.
- R2: After a falling edge of `vsync_n`, the word is taken from the lines that begin at the 3rd through the 13th falling edges of `hsync_n`. The first of these bits is the most significant bit. The data on every other line has no effect on the word.
- R3: Each bit is sampled half of the most recently measured `hsync_n` period after that line's falling edge. A value that is present only during the first sixth of a line has no effect on the sampled bit.
- R4: When the 11th bit has been taken, `line_count` takes the new word. If the word appears in the map of R5, `word_valid` goes high for exactly one clock cycle, in the same cycle as the update. If the word is not in the map, `word_valid` stays low.
- R5: The map from word to code is as follows. 259 or 260 gives code 1 (525-line interlaced). 309 or 310 gives code 2 (625-line interlaced). 522 gives code 3 (525-line progressive). 622 gives code 4 (625-line progressive). 747 gives code 5 (720-line progressive). 559 or 560 gives code 6 (1080-line interlaced). 1122 gives code 7 (1080-line progressive). Every other value gives code 0.
- R6: `fmt_code`, `interlaced` and `composite` change only when a completed word gives the same code as the word completed just before it. In every other case they keep their values.
- R7: When two consecutive words are both outside the map, `fmt_code` becomes 0 and both flags become 0.
- R8: When the outputs are updated to a known code, `composite` equals the third transmitted bit, which is bit 8 of the word.
- R9: A new falling edge of `vsync_n` during a capture drops that capture and starts a fresh one.
- R10: `interlaced` is 1 exactly when the code being applied is 1, 2 or 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_n | input | 1 | Horizontal sync, active low, acts as the bit strobe |
| vsync_n | input | 1 | Vertical sync, active low, acts as the field marker |
| fmt_bit | input | 1 | Serial lines-per-field data |
| line_count | output | 11 | Most recently completed word |
| fmt_code | output | 4 | Agreed format code (see R5) |
| interlaced | output | 1 | Agreed format is interlaced |
| composite | output | 1 | Agreed format is composite (third bit of the word) |
| word_valid | output | 1 | One-cycle pulse for a completed word that is in the map |

## Verification
The case that is hardest to reach from the ports is a vertical sync edge that arrives partway through a capture. The stimulus sends a partial field whose data is the inverse of the real word. It then raises a second vertical sync edge while the capture is still running, and follows it with a full field. Every line also carries a wrong value for its first few cycles. This shows that only the mid-line sample is used. Format changes are sent as pairs of fields, so the checks see the outputs holding after the first field and updating after the second.

// File: rtl/fwd_pkg.sv
// Package for the lines-per-field decoder: format codes and the map from count to format.
// Assumes an 11-bit word sent MSB first.
package fwd_pkg;
    localparam int WORD_W = 11;

    typedef enum logic [3:0] {
        FMT_NONE    = 4'd0,
        FMT_SD525I  = 4'd1,
        FMT_SD625I  = 4'd2,
        FMT_ED525P  = 4'd3,
        FMT_ED625P  = 4'd4,
        FMT_HD720P  = 4'd5,
        FMT_HD1080I = 4'd6,
        FMT_HD1080P = 4'd7
    } fmt_e;

    // Map a received count to a format; only exact listed counts match.
    function automatic fmt_e classify(input logic [WORD_W-1:0] w);
        case (w)
            11'd259, 11'd260:  return FMT_SD525I;
            11'd309, 11'd310:  return FMT_SD625I;
            11'd522:           return FMT_ED525P;
            11'd622:           return FMT_ED625P;
            11'd747:           return FMT_HD720P;
            11'd559, 11'd560:  return FMT_HD1080I;
            11'd1122:          return FMT_HD1080P;
            default:           return FMT_NONE;
        endcase
    endfunction

    // True for the formats that alternate two field counts.
    function automatic logic is_interlaced(input fmt_e f);
        return (f == FMT_SD525I) || (f == FMT_SD625I) || (f == FMT_HD1080I);
    endfunction
endpackage

// File: rtl/fwd_edge_det.sv
// Falling-edge detector for an active-low strobe.
// Assumes sig_n is already synchronous to clk; it adds two register stages.
module fwd_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_n,
    output logic fall
);
    logic q1, q2;

    // Delay line that the edge comparison uses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q1 <= 1'b1;
            q2 <= 1'b1;
        end else begin
            q1 <= sig_n;
            q2 <= q1;
        end
    end

    assign fall = q2 & ~q1;
endmodule

// File: rtl/fwd_line_timer.sv
// Measures the line period between line_start pulses. Raises mid_stb once per line,
// half of the previous period after each line_start.
// Assumes the lines are at least two clocks long; the period counter saturates.
module fwd_line_timer #(
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    output logic mid_stb
);
    logic [CNT_W-1:0] run_cnt, half_len, dly_cnt;
    logic             armed;

    // Period measurement: latch half of the elapsed count at each line start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            half_len <= '0;
        end else if (line_start) begin
            half_len <= CNT_W'(({1'b0, run_cnt} + 1'b1) >> 1);
            run_cnt  <= '0;
        end else if (run_cnt != '1) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Delay counter that places one strobe in the middle of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            dly_cnt <= '0;
        end else if (line_start) begin
            armed   <= 1'b1;
            dly_cnt <= '0;
        end else if (mid_stb) begin
            armed   <= 1'b0;
        end else if (armed) begin
            dly_cnt <= dly_cnt + 1'b1;
        end
    end

    assign mid_stb = armed && (half_len != '0) && (dly_cnt == half_len - 1'b1);

    AST_STB_ONE_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_stb && !line_start) |=> !mid_stb); // R3
endmodule

// File: rtl/fwd_bit_capture.sv
// Counts line starts after a field marker. Shifts in one bit at the mid-line strobe
// of lines START_EDGE .. START_EDGE+WORD_W-1 and pulses done after the last bit.
// Assumes frame_start and line_start do not fall in the same cycle; if they do, the line start is ignored.
module fwd_bit_capture #(
    parameter int WORD_W     = 11,
    parameter int START_EDGE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              mid_stb,
    input  logic              data_bit,
    output logic [WORD_W-1:0] word,
    output logic              done
);
    localparam int LAST_EDGE = START_EDGE + WORD_W - 1;
    localparam int EW        = $clog2(LAST_EDGE + 1);

    logic [EW-1:0] edge_idx;
    logic          active;
    logic          in_window;
    logic          last_bit;

    assign in_window = active && mid_stb && !frame_start &&
                       (edge_idx >= EW'(START_EDGE)) && (edge_idx <= EW'(LAST_EDGE));
    assign last_bit  = in_window && (edge_idx == EW'(LAST_EDGE));

    // Line index since the field marker; a new marker restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_idx <= '0;
            active   <= 1'b0;
        end else if (frame_start) begin
            edge_idx <= '0;
            active   <= 1'b1;
        end else if (active && line_start) begin
            edge_idx <= edge_idx + 1'b1;
        end else if (last_bit) begin
            active   <= 1'b0;
        end
    end

    // Shift register, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)         word <= '0;
        else if (in_window) word <= {word[WORD_W-2:0], data_bit};
    end

    // Completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= last_bit;
    end

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mid_stb)); // R3
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (edge_idx <= EW'(LAST_EDGE))); // R2
endmodule

// File: rtl/fwd_classifier.sv
// Turns each completed word into a format. Applies a format only after two
// consecutive words agree, and pulses word_valid for words that are in the map.
// Assumes word_done lasts one cycle and word is stable in that cycle.
module fwd_classifier
    import fwd_pkg::*;
#(
    parameter int COMP_POS = WORD_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] line_count,
    output fmt_e              fmt_q,
    output logic              interlaced,
    output logic              composite,
    output logic              word_valid
);
    fmt_e cand, prev_cand;

    assign cand = classify(word);

    // Count register, strobe, and the two-field agreement filter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_count <= '0;
            fmt_q      <= FMT_NONE;
            prev_cand  <= FMT_NONE;
            interlaced <= 1'b0;
            composite  <= 1'b0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= word_done && (cand != FMT_NONE);
            if (word_done) begin
                line_count <= word;
                prev_cand  <= cand;
                if (cand == prev_cand) begin
                    fmt_q      <= cand;
                    interlaced <= is_interlaced(cand);
                    composite  <= (cand != FMT_NONE) && word[COMP_POS];
                end
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R4
    AST_VALID_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(word_done)); // R4
    AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(word_done) |-> ($stable(fmt_q) && $stable(composite))); // R6
    AST_IL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        interlaced |-> (fmt_q == FMT_SD525I || fmt_q == FMT_SD625I || fmt_q == FMT_HD1080I)); // R10
endmodule

// File: rtl/fmt_word_decoder.sv
// Top of the lines-per-field decoder: edge detection, mid-line timing,
// serial capture and format classification.
// Assumes sync inputs are active low and synchronous to clk.
module fmt_word_decoder #(
    parameter int CNT_W      = 12,
    parameter int START_EDGE = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hsync_n,
    input  logic        vsync_n,
    input  logic        fmt_bit,
    output logic [10:0] line_count,
    output logic [3:0]  fmt_code,
    output logic        interlaced,
    output logic        composite,
    output logic        word_valid
);
    import fwd_pkg::*;

    logic              hs_fall, vs_fall, mid_stb, done;
    logic              bit_q1, bit_q2;
    logic [WORD_W-1:0] word;
    fmt_e              fmt_q;

    // Data delay that matches the latency of the edge detectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q1 <= 1'b0;
            bit_q2 <= 1'b0;
        end else begin
            bit_q1 <= fmt_bit;
            bit_q2 <= bit_q1;
        end
    end

    fwd_edge_det u_hs (.clk(clk), .rst_n(rst_n), .sig_n(hsync_n), .fall(hs_fall));
    fwd_edge_det u_vs (.clk(clk), .rst_n(rst_n), .sig_n(vsync_n), .fall(vs_fall));

    fwd_line_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .line_start(hs_fall), .mid_stb(mid_stb));

    fwd_bit_capture #(.WORD_W(WORD_W), .START_EDGE(START_EDGE)) u_cap (
        .clk(clk), .rst_n(rst_n), .frame_start(vs_fall), .line_start(hs_fall),
        .mid_stb(mid_stb), .data_bit(bit_q2), .word(word), .done(done));

    fwd_classifier u_cls (
        .clk(clk), .rst_n(rst_n), .word_done(done), .word(word),
        .line_count(line_count), .fmt_q(fmt_q), .interlaced(interlaced),
        .composite(composite), .word_valid(word_valid));

    assign fmt_code = fmt_q;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (!word_valid && fmt_code == 4'd0)); // R1
endmodule

// File: tb/sim_fmt_word_decoder.sv
module sim_fmt_word_decoder;
    localparam int LINE = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync_n = 1'b1;
    logic        vsync_n = 1'b1;
    logic        fmt_bit = 1'b0;
    logic [10:0] line_count;
    logic [3:0]  fmt_code;
    logic        interlaced, composite, word_valid;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int wide = 0;
    logic prev_v = 1'b0;

    // Model state derived from the requirements
    int exp_code = 0;
    int prev_cand = 0;
    logic exp_il = 1'b0;
    logic exp_comp = 1'b0;

    always #10 clk = ~clk;

    fmt_word_decoder u0 (
        .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .fmt_bit(fmt_bit), .line_count(line_count), .fmt_code(fmt_code),
        .interlaced(interlaced), .composite(composite), .word_valid(word_valid));

    // Port monitor for valid pulses
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid) begin
                pulses++;
                if (prev_v) wide++;
            end
            prev_v = word_valid;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R5 map, written out in the bench
    function automatic int code_of(input int w);
        case (w)
            259, 260: return 1;
            309, 310: return 2;
            522:      return 3;
            622:      return 4;
            747:      return 5;
            559, 560: return 6;
            1122:     return 7;
            default:  return 0;
        endcase
    endfunction

    // One line: hsync low for 4 clocks, data wrong for the first 6 clocks (R3)
    task automatic run_line(input logic b, input int vs_cmd);
        @(negedge clk);
        hsync_n = 1'b0;
        fmt_bit = ~b;
        for (int i = 1; i < LINE; i++) begin
            @(negedge clk);
            if (i == 4) hsync_n = 1'b1;
            if (i == 6) fmt_bit = b;
            if (i == 28 && vs_cmd == 1) vsync_n = 1'b0;
            if (i == 28 && vs_cmd == 2) vsync_n = 1'b1;
        end
    endtask

    task automatic send_field(input logic [10:0] w, input int abort_after);
        if (abort_after > 0) begin
            run_line(1'b1, 1);
            for (int k = 1; k <= 2 + abort_after; k++)
                run_line(~w[10 - ((k - 3 < 0) ? 0 : k - 3)], (k == 3) ? 2 : 0);
        end
        run_line(1'b1, 1);
        run_line(~w[10], 0);
        run_line(~w[9], 0);
        for (int k = 0; k < 11; k++) run_line(w[10 - k], (k == 0) ? 2 : 0);
        run_line(~w[0], 0);
    endtask

    // Sends one field and checks every output against the model
    task automatic field_check(input int w, input int abort_after, input string tag);
        int p0, c;
        p0 = pulses;
        c = code_of(w);
        send_field(11'(w), abort_after);
        if (c == prev_cand) begin
            exp_code = c;
            exp_il   = (c == 1 || c == 2 || c == 6);
            exp_comp = (c != 0) && ((w >> 8) & 1);
        end
        prev_cand = c;
        chk({"R2 line_count ", tag}, int'(line_count), w);
        chk({"R4 pulses ", tag}, pulses - p0, (c != 0) ? 1 : 0);
        chk({"R4 width ", tag}, wide, 0);
        chk({"R5 R6 R7 fmt_code ", tag}, int'(fmt_code), exp_code);
        chk({"R10 interlaced ", tag}, int'(interlaced), int'(exp_il));
        chk({"R8 composite ", tag}, int'(composite), int'(exp_comp));
    endtask

    task automatic t_reset;
        repeat (5) @(negedge clk);
        chk("R1 line_count", int'(line_count), 0);
        chk("R1 fmt_code", int'(fmt_code), 0);
        chk("R1 flags", int'({interlaced, composite, word_valid}), 0);
        rst_n = 1'b1;
        repeat (3) run_line(1'b0, 0);
        chk("R1 no pulse after reset", pulses, 0);
    endtask

    task automatic t_sd_interlaced;
        field_check(260, 0, "525i f1");
        field_check(259, 0, "525i f2");
        field_check(310, 0, "625i f1");
        field_check(309, 0, "625i f2");
    endtask

    task automatic t_progressive;
        field_check(1122, 0, "1080p a");
        field_check(1122, 0, "1080p b");
        field_check(522, 0, "480p a");
        field_check(522, 0, "480p b");
        field_check(622, 0, "576p a");
        field_check(622, 0, "576p b");
        field_check(747, 0, "720p a");
        field_check(747, 0, "720p b");
    endtask

    task automatic t_hd_interlaced;
        field_check(560, 0, "1080i f1");
        field_check(559, 0, "1080i f2");
    endtask

    task automatic t_unknown;
        field_check(261, 0, "unknown a");
        field_check(1000, 0, "unknown b");
    endtask

    task automatic t_restart;
        field_check(622, 3, "R9 restart a");
        field_check(622, 2, "R9 restart b");
    endtask

    initial begin
        t_reset;
        t_sd_interlaced;
        t_progressive;
        t_hd_interlaced;
        t_unknown;
        t_restart;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule